// File: doc/BRIEF.md
# Low-Latency Frame Buffer Controller

This block decides which storage slot a video frame is written into, which slot the output side reads from, and when the output side may fetch a pixel. The input side marks each frame with a start strobe and delivers pixels in raster order with a valid strobe. The output side marks each output frame with a start strobe and asks for pixels one at a time. The frame store is held inside the block as a small array of whole-frame slots.

The buffering scheme follows a mode input. In free-running mode three slots rotate, so the output can drop or repeat frames when the two rates differ. In locked mode the rates match, so two slots alternate. The reader then opens the slot that is still being filled and trails the writer by a programmed number of lines, so output starts well before the frame is complete.

A watchdog counts output frames that pass without any input frame start. Once a programmed limit is reached, it blanks whole output frames to zero instead of repeating stale content.

Top module: `fbc_frame_ctrl`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0, `underrun` is 0, and both `wr_slot` and `rd_slot` are 0. Read requests are ignored until the first `rd_frame_start`.
- R2: In free-running mode (`lock_en`=0), each `wr_frame_start` selects as its write slot the lowest-numbered slot that is neither the current read slot nor the slot holding the newest complete frame.
- R3: In free-running mode, each `rd_frame_start` moves the read slot to the newest complete frame. If no frame has completed since the last move, the slot is unchanged and the same frame is read again.
- R4: In locked mode (`lock_en`=1), each `wr_frame_start` makes the write slot alternate between slots 0 and 1. Slot 2 is never used in this mode.
- R5: In locked mode, `rd_frame_start` selects the slot currently being written. This includes a write frame that starts in the same cycle.
- R6: In locked mode, a request for read line L is granted only when one of two conditions holds:
  - the writer has completed more than L + `line_offset` lines of its current frame, or
  - the writer has completed the whole frame.
  A refused request leaves the read position unchanged and sets `underrun`, which then stays at 1 until reset.
- R7: On each `rd_frame_start`, the block counts output frames since the last `wr_frame_start`. A `wr_frame_start` resets this count.
  - If the count reaches `loss_limit` (non-zero), that whole output frame is delivered as zero pixels and every request in it is granted.
  - A `loss_limit` of 0 disables blanking.
  - The blank state is re-evaluated only at output frame starts.
- R8: A granted request returns `rd_valid`=1 one clock later. The pixels of a frame come out in raster order, exactly as written.
- R9: A write frame that is restarted before all of its LINE_PIX×FRAME_LINES pixels arrive never becomes the newest complete frame.
- R10: No effect on the slots or the output comes from any of these:
  - a `rd_req` in the cycle of `rd_frame_start`;
  - a `rd_req` after the last pixel of a frame;
  - a `wr_valid` in the cycle of `wr_frame_start`.
- R11: In free-running mode, reading before any frame has completed yields granted zero pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| lock_en | input | 1 | 1 = locked double buffering, 0 = free-running triple buffering |
| line_offset | input | LINE_W (3) | Lines the reader trails the writer in locked mode |
| loss_limit | input | LOSS_W (8) | Output frames without input before blanking; 0 disables |
| wr_frame_start | input | 1 | Input frame start strobe |
| wr_valid | input | 1 | Input pixel strobe |
| wr_data | input | PIX_W (8) | Input pixel |
| rd_frame_start | input | 1 | Output frame start strobe |
| rd_req | input | 1 | Output pixel request |
| rd_valid | output | 1 | Output pixel delivered this cycle |
| rd_data | output | PIX_W (8) | Output pixel |
| underrun | output | 1 | Sticky: a locked-mode read was held back |
| wr_slot | output | SLOT_W (2) | Slot being written |
| rd_slot | output | SLOT_W (2) | Slot being read |

## Verification
The assertions assume the following about the block's inputs:
- Frame-start strobes last one cycle.
- `lock_en` and `line_offset` change only while both sides are idle between frames.
- In locked mode, the writer's frame start comes no later than the reader's.

The stimulus respects these rules. It switches mode only after a read frame has drained. It issues every locked write start one cycle ahead of the matching read start, and it drives all inputs on the falling edge. The slot-alternation and trailing-gate properties rely on these rules. The gate property also treats a completed write frame as always readable.

// File: rtl/fbc_pkg.sv
// Shared definitions for the frame buffer controller.
package fbc_pkg;
    typedef enum logic {
        BUF_TRIPLE = 1'b0,
        BUF_DOUBLE = 1'b1
    } buf_mode_e;
endpackage

// File: rtl/fbc_write_side.sv
// Write side: picks the slot for each incoming frame, walks the raster
// position, and publishes a slot as newest once its frame is complete.
// Assumes frame_start is a single-cycle strobe and pixels arrive in raster order.
module fbc_write_side
    import fbc_pkg::*;
#(
    parameter int SLOTS       = 3,
    parameter int LINE_PIX    = 8,
    parameter int FRAME_LINES = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int COL_W  = $clog2(LINE_PIX),
    localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  buf_mode_e         mode,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] pick_slot,
    output logic [COL_W-1:0]  cur_col,
    output logic [LINE_W-1:0] lines_done,
    output logic [SLOT_W-1:0] newest,
    output logic              newest_ok,
    output logic              wr_en
);
    logic active;

    // Slot for the next frame: alternate 0/1 when locked, else the lowest free slot.
    always_comb begin
        pick_slot = '0;
        if (mode == BUF_DOUBLE) begin
            pick_slot = (cur_slot == '0) ? SLOT_W'(1) : '0;
        end else begin
            for (int i = SLOTS - 1; i >= 0; i--) begin
                if (SLOT_W'(i) != rd_slot && !(newest_ok && SLOT_W'(i) == newest))
                    pick_slot = SLOT_W'(i);
            end
        end
    end

    // A pixel is stored only inside an open frame and never on the start cycle.
    assign wr_en = pix_valid && active && !frame_start;

    // Raster position, frame completion and newest-frame bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_slot   <= '0;
            cur_col    <= '0;
            lines_done <= '0;
            active     <= 1'b0;
            newest     <= '0;
            newest_ok  <= 1'b0;
        end else if (frame_start) begin
            cur_slot   <= pick_slot;
            cur_col    <= '0;
            lines_done <= '0;
            active     <= 1'b1;
        end else if (wr_en) begin
            if (cur_col == COL_W'(LINE_PIX - 1)) begin
                cur_col    <= '0;
                lines_done <= lines_done + 1'b1;
                if (lines_done == LINE_W'(FRAME_LINES - 1)) begin
                    active    <= 1'b0;
                    newest    <= cur_slot;
                    newest_ok <= 1'b1;
                end
            end else begin
                cur_col <= cur_col + 1'b1;
            end
        end
    end

    // R4: locked frames alternate between the two low slots.
    a_r4_double_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode == BUF_DOUBLE) |=> (cur_slot != $past(cur_slot)) && (cur_slot < SLOT_W'(2)));

    // R9: the completed-line count never passes the frame height.
    a_r9_lines_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lines_done <= LINE_W'(FRAME_LINES));
endmodule

// File: rtl/fbc_read_side.sv
// Read side: chooses the slot at each output frame start, walks the raster
// position on granted requests, and holds a locked reader behind the writer.
// Assumes rd frame starts are single-cycle strobes.
module fbc_read_side
    import fbc_pkg::*;
#(
    parameter int SLOTS       = 3,
    parameter int LINE_PIX    = 8,
    parameter int FRAME_LINES = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int COL_W  = $clog2(LINE_PIX),
    localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  buf_mode_e         mode,
    input  logic              frame_start,
    input  logic              req,
    input  logic              blank,
    input  logic [SLOT_W-1:0] live_slot,
    input  logic [SLOT_W-1:0] newest,
    input  logic              newest_ok,
    input  logic [LINE_W-1:0] wr_lines,
    input  logic [LINE_W-1:0] offset,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [COL_W-1:0]  cur_col,
    output logic [LINE_W-1:0] cur_line,
    output logic              grant,
    output logic              zero_fill,
    output logic              underrun
);
    logic has_content;
    logic in_frame;
    logic caught_up;
    logic allowed;
    logic stall;

    // Decide whether the pending request may be served this cycle.
    always_comb begin
        in_frame  = cur_line < LINE_W'(FRAME_LINES);
        caught_up = (wr_lines == LINE_W'(FRAME_LINES)) ||
                    ({1'b0, wr_lines} > ({1'b0, cur_line} + {1'b0, offset}));
        allowed   = blank || (mode == BUF_TRIPLE) || caught_up;
        grant     = req && !frame_start && in_frame && allowed;
        stall     = req && !frame_start && in_frame && !allowed;
    end

    assign zero_fill = blank || !has_content;

    // Slot choice at frame start and raster advance on grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_slot    <= '0;
            cur_col     <= '0;
            cur_line    <= LINE_W'(FRAME_LINES);
            has_content <= 1'b0;
        end else if (frame_start) begin
            cur_col  <= '0;
            cur_line <= '0;
            if (mode == BUF_DOUBLE) begin
                cur_slot    <= live_slot;
                has_content <= 1'b1;
            end else if (newest_ok) begin
                cur_slot    <= newest;
                has_content <= 1'b1;
            end
        end else if (grant) begin
            if (cur_col == COL_W'(LINE_PIX - 1)) begin
                cur_col  <= '0;
                cur_line <= cur_line + 1'b1;
            end else begin
                cur_col <= cur_col + 1'b1;
            end
        end
    end

    // Sticky record of any locked-mode hold.
    always_ff @(posedge clk) begin
        if (!rst_n) underrun <= 1'b0;
        else if (stall) underrun <= 1'b1;
    end

    // R6: once raised, the underrun flag stays up.
    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R6: a held request leaves the read position where it was.
    a_r6_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !frame_start && !grant) |=> $stable(cur_line) && $stable(cur_col));
endmodule

// File: rtl/fbc_loss_watch.sv
// Input-loss watchdog: counts output frames since the last input frame start
// and blanks whole output frames once the programmed limit is reached.
// Assumes both start strobes are single-cycle; a limit of zero disables it.
module fbc_loss_watch #(
    parameter int LOSS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              rd_start,
    input  logic [LOSS_W-1:0] limit,
    output logic              blank
);
    logic [LOSS_W-1:0] frames_idle;
    logic [LOSS_W:0]   idle_inc;

    assign idle_inc = {1'b0, frames_idle} + 1'b1;

    // Idle-frame counter, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) frames_idle <= '0;
        else if (wr_start) frames_idle <= '0;
        else if (rd_start && !(&frames_idle)) frames_idle <= idle_inc[LOSS_W-1:0];
    end

    // Blank decision, taken only at output frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) blank <= 1'b0;
        else if (rd_start) blank <= !wr_start && (limit != '0) && (idle_inc >= {1'b0, limit});
    end

    // R7: an input frame start at an output frame start never blanks it.
    a_r7_input_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && rd_start) |=> !blank);

    // R7: a zero limit disables blanking.
    a_r7_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && limit == '0) |=> !blank);
endmodule

// File: rtl/fbc_frame_ctrl.sv
// Frame buffer controller top: slot storage plus write side, read side and
// input-loss watchdog. Read data is registered, one cycle after a grant.
// Assumes lock_en and line_offset only change while both sides are idle.
module fbc_frame_ctrl
    import fbc_pkg::*;
#(
    parameter int PIX_W       = 8,
    parameter int SLOTS       = 3,
    parameter int LINE_PIX    = 8,
    parameter int FRAME_LINES = 4,
    parameter int LOSS_W      = 8,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int COL_W     = $clog2(LINE_PIX),
    localparam int LINE_W    = $clog2(FRAME_LINES + 1),
    localparam int FRAME_PIX = LINE_PIX * FRAME_LINES,
    localparam int DEPTH     = SLOTS * FRAME_PIX,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_en,
    input  logic [LINE_W-1:0] line_offset,
    input  logic [LOSS_W-1:0] loss_limit,
    input  logic              wr_frame_start,
    input  logic              wr_valid,
    input  logic [PIX_W-1:0]  wr_data,
    input  logic              rd_frame_start,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [PIX_W-1:0]  rd_data,
    output logic              underrun,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] rd_slot
);
    buf_mode_e         mode;
    logic [SLOT_W-1:0] pick_slot;
    logic [SLOT_W-1:0] live_slot;
    logic [COL_W-1:0]  w_col;
    logic [LINE_W-1:0] w_lines;
    logic [SLOT_W-1:0] newest;
    logic              newest_ok;
    logic              w_en;
    logic [COL_W-1:0]  r_col;
    logic [LINE_W-1:0] r_line;
    logic              r_grant;
    logic              r_zero;
    logic              blank;
    logic [ADDR_W-1:0] w_addr;
    logic [ADDR_W-1:0] r_addr;
    logic [PIX_W-1:0]  store [DEPTH];

    assign mode      = lock_en ? BUF_DOUBLE : BUF_TRIPLE;
    assign live_slot = wr_frame_start ? pick_slot : wr_slot;
    assign w_addr    = ADDR_W'(int'(wr_slot) * FRAME_PIX + int'(w_lines) * LINE_PIX + int'(w_col));
    assign r_addr    = ADDR_W'(int'(rd_slot) * FRAME_PIX + int'(r_line) * LINE_PIX + int'(r_col));

    fbc_write_side #(.SLOTS(SLOTS), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_wr (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frame_start(wr_frame_start),
        .pix_valid(wr_valid), .rd_slot(rd_slot), .cur_slot(wr_slot),
        .pick_slot(pick_slot), .cur_col(w_col), .lines_done(w_lines),
        .newest(newest), .newest_ok(newest_ok), .wr_en(w_en)
    );

    fbc_read_side #(.SLOTS(SLOTS), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_rd (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frame_start(rd_frame_start),
        .req(rd_req), .blank(blank), .live_slot(live_slot), .newest(newest),
        .newest_ok(newest_ok), .wr_lines(w_lines), .offset(line_offset),
        .cur_slot(rd_slot), .cur_col(r_col), .cur_line(r_line),
        .grant(r_grant), .zero_fill(r_zero), .underrun(underrun)
    );

    fbc_loss_watch #(.LOSS_W(LOSS_W)) u_loss (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_frame_start),
        .rd_start(rd_frame_start), .limit(loss_limit), .blank(blank)
    );

    // Frame storage write port.
    always_ff @(posedge clk) begin
        if (w_en) store[w_addr] <= wr_data;
    end

    // Registered read port: zero when blanked or nothing to show.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= r_grant;
            if (r_grant) rd_data <= r_zero ? '0 : store[r_addr];
        end
    end

    // R2: a free-running writer never shares the reader's slot.
    a_r2_slot_split: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_start && !lock_en) |=> wr_slot != rd_slot);

    // R6: a locked reader ahead of the trailing window gets no pixel.
    a_r6_trail_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && !blank && rd_req && !rd_frame_start && w_lines < LINE_W'(FRAME_LINES) &&
         ({1'b0, w_lines} <= ({1'b0, r_line} + {1'b0, line_offset}))) |=> !rd_valid);

    // R7: pixels served in a blanked frame are zero.
    a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_grant && blank) |=> rd_data == '0);

    // R8: every delivered pixel answers a request in the previous cycle.
    a_r8_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
endmodule

// File: tb/sim_fbc_frame_ctrl.sv
`timescale 1ns/1ps
module sim_fbc_frame_ctrl;
    localparam int FP = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_en = 1'b0;
    logic [2:0] line_offset = '0;
    logic [7:0] loss_limit = 8'd3;
    logic       wr_frame_start = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_frame_start = 1'b0;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       underrun;
    logic [1:0] wr_slot;
    logic [1:0] rd_slot;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rx_count = 0;
    int first_rx_cyc = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fbc_frame_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .line_offset(line_offset),
        .loss_limit(loss_limit), .wr_frame_start(wr_frame_start), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_frame_start(rd_frame_start), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .underrun(underrun),
        .wr_slot(wr_slot), .rd_slot(rd_slot)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int id, input int i);
        return 8'((id * FP + i) & 255);
    endfunction

    // Monitor: pops the scoreboard for every delivered pixel (R8, R10).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (rx_count == 0) first_rx_cyc = cyc;
            rx_count++;
            if (exp_q.size() == 0) check(1'b0, "R10 unexpected pixel", int'(rd_data), -1);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check(rd_data == e, "R8 pixel value", int'(rd_data), int'(e));
            end
        end
    end

    // Write one input frame; the start cycle carries a junk pixel (R10).
    task automatic write_frame(input int id, input int npix);
        @(negedge clk);
        wr_frame_start = 1'b1; wr_valid = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_frame_start = 1'b0;
        for (int i = 0; i < npix; i++) begin
            wr_valid = 1'b1; wr_data = pix(id, i);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    // Read one free-running output frame; id < 0 expects zeros.
    task automatic read_frame(input int id, input string req);
        for (int i = 0; i < FP; i++) exp_q.push_back(id < 0 ? 8'h00 : pix(id, i));
        rx_count = 0;
        @(negedge clk);
        rd_frame_start = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        rd_frame_start = 1'b0;
        for (int i = 0; i < FP + 1; i++) @(negedge clk);
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {req, " frame drained"}, exp_q.size(), 0);
        check(rx_count == FP, "R10 pixel count per frame", rx_count, FP);
        exp_q.delete();
    endtask

    // Locked frame: writer and trailing reader run together.
    task automatic run_locked(input int id, input logic [2:0] off, output int wdone);
        int wn;
        for (int i = 0; i < FP; i++) exp_q.push_back(pix(id, i));
        rx_count = 0;
        line_offset = off;
        wdone = 0;
        @(negedge clk);
        wr_frame_start = 1'b1;
        @(negedge clk);
        wr_frame_start = 1'b0;
        rd_frame_start = 1'b1;
        wr_valid = 1'b1; wr_data = pix(id, 0); wn = 1;
        @(negedge clk);
        rd_frame_start = 1'b0;
        if (wn == FP) wdone = cyc;
        for (int c = 0; c < 300; c++) begin
            wr_valid = (wn < FP);
            if (wn < FP) begin
                wr_data = pix(id, wn);
                wn++;
            end
            rd_req = (rx_count < FP);
            @(negedge clk);
            if (wn == FP && wdone == 0) wdone = cyc;
            if (rx_count >= FP && wn >= FP) break;
        end
        wr_valid = 1'b0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 locked frame drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(5.0 * 20000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wd;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        check(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
        check(underrun == 1'b0, "R1 underrun in reset", underrun, 0);
        check(rd_slot == 2'd0 && wr_slot == 2'd0, "R1 slots in reset", {wr_slot, rd_slot}, 0);
        rst_n = 1'b1;
        // R1: requests before any read frame start are ignored
        @(negedge clk); rd_req = 1'b1;
        repeat (3) @(negedge clk); rd_req = 1'b0;
        @(negedge clk);
        check(rx_count == 0, "R1 request before frame start ignored", rx_count, 0);

        // R11: nothing complete yet -> zero pixels, slot unchanged
        read_frame(-1, "R11");
        check(rd_slot == 2'd0, "R11 slot kept without content", rd_slot, 0);

        // R2/R3: first frame goes to slot 1, reader follows
        write_frame(1, FP);
        check(wr_slot == 2'd1, "R2 first write slot", wr_slot, 1);
        read_frame(1, "R3");
        check(rd_slot == 2'd1, "R3 reader takes newest", rd_slot, 1);

        // R2/R3: two frames while reader idle -> older one dropped
        write_frame(2, FP);
        check(wr_slot == 2'd0, "R2 write avoids read and newest", wr_slot, 0);
        write_frame(3, FP);
        check(wr_slot == 2'd2, "R2 third slot picked", wr_slot, 2);
        read_frame(3, "R3 drop");
        check(rd_slot == 2'd2, "R3 reader jumps to newest", rd_slot, 2);
        read_frame(3, "R3 repeat");
        check(rd_slot == 2'd2, "R3 repeat keeps slot", rd_slot, 2);

        // R9: a restarted partial frame is never shown
        write_frame(4, FP / 2);
        check(wr_slot == 2'd0, "R9 partial frame slot", wr_slot, 0);
        read_frame(3, "R9");
        write_frame(5, FP);
        check(wr_slot == 2'd0, "R9 restart reuses slot", wr_slot, 0);
        read_frame(5, "R9 new frame");
        check(underrun == 1'b0, "R6 no underrun when free-running", underrun, 0);

        // R7: blanking after the limit, cleared by new input
        loss_limit = 8'd2;
        read_frame(-1, "R7 blank");
        read_frame(-1, "R7 blank again");
        write_frame(6, FP);
        read_frame(6, "R7 recovery");
        loss_limit = 8'd0;
        read_frame(6, "R7 disabled");
        read_frame(6, "R7 disabled");
        read_frame(6, "R7 disabled");

        // R4/R5/R6: locked double buffering
        lock_en = 1'b1;
        run_locked(7, 3'd1, wd);
        check(wr_slot == 2'd0, "R4 locked write slot", wr_slot, 0);
        check(rd_slot == 2'd0, "R5 reader on live slot", rd_slot, 0);
        check(first_rx_cyc < wd, "R5 read starts before write done", first_rx_cyc, wd);
        check(underrun == 1'b1, "R6 underrun raised by hold", underrun, 1);
        run_locked(2, 3'd3, wd);
        check(wr_slot == 2'd1, "R4 locked slot alternates", wr_slot, 1);
        check(rd_slot == 2'd1, "R5 reader follows live slot", rd_slot, 1);
        check(first_rx_cyc > wd, "R6 large offset waits for full frame", first_rx_cyc, wd);
        check(underrun == 1'b1, "R6 underrun stays set", underrun, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule